// File: doc/BRIEF.md
# Bulk OUT Endpoint Control/Status Register

This block holds the control/status word of one bulk OUT endpoint. It sits between a 32-bit CPU register port and the USB-side receive engine. The engine signals each byte it puts into the receive FIFO, each complete packet (with a flag when the packet was short), each STALL handshake it has sent, and each packet the CPU has fully drained. The CPU signals each byte it pops. From these events the block keeps a byte occupancy count and a count of complete packets held, so it can tell "some data present" apart from "at least one whole packet ready".

The CPU sees one register word that mixes three kinds of bits. Some are read-only and follow the FIFO contents, some are sticky event bits that the CPU clears by writing 1, and one is a read/write control that makes the endpoint answer OUT tokens with STALL. That control also leaves the block as a level to the protocol engine. Reads are combinational from registered state. Every event and every write takes effect at the next rising clock edge.

Top module: `epo_csr`

## Requirements
- R1: After synchronous active-low reset the register reads 0x00000000 and `force_stall` is 0.
- R2: Bit 0 (FIFO service) reads 1 while the FIFO holds one or more complete packets and 0 otherwise. A packet counts from its `rx_pkt_done` until its `rx_pkt_drained`, and up to 2 packets are tracked.
- R3: Bit 6 (not empty) reads 1 while the byte count is nonzero. `rx_byte_push` adds one byte, `rx_byte_pop` removes one, and both in the same cycle leave the count unchanged.
- R4: Bit 7 (short packet) reads 1 while a packet completed with `rx_pkt_short`=1 is still in the FIFO. It clears when the drain of that packet is reported, and packets drain in arrival order.
- R5: Bit 5 (force stall) takes `csr_wdata[5]` on every write and drives `force_stall`.
- R6: Bit 4 (sent stall) sets on `stall_sent` and clears only when a write has `csr_wdata[4]`=1. Writing 0 there leaves it set.
- R7: Bit 1 (packet complete) sets on `rx_pkt_done` and clears only when a write has `csr_wdata[1]`=1.
- R8: When a hardware set and a write-1 clear reach bit 4 or bit 1 in the same cycle, the bit ends up set.
- R9: Bits 31:8, 3 and 2 always read 0. Writes have no effect on bits 7, 6 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_en | input | 1 | CPU write strobe for the register |
| csr_wdata | input | 32 | CPU write data |
| csr_rdata | output | 32 | Register read value |
| rx_byte_push | input | 1 | Engine put one byte into the receive FIFO |
| rx_byte_pop | input | 1 | CPU took one byte from the receive FIFO |
| rx_pkt_done | input | 1 | Engine finished receiving one packet |
| rx_pkt_short | input | 1 | Qualifies `rx_pkt_done`: that packet was short |
| rx_pkt_drained | input | 1 | Last byte of the oldest held packet was taken |
| stall_sent | input | 1 | Engine sent a STALL handshake |
| force_stall | output | 1 | Level to the engine: answer OUT tokens with STALL |

## Verification
Byte-only traffic without packet completions shows that the not-empty flag follows the byte count on its own while the service flag stays low. Two packets in flight, a normal one ahead of a short one, separate the packet count from occupancy and show that the short flag survives the first drain and falls on the second. Writes of 0, writes of 1 and writes that collide with hardware set events separate the sticky clear rule, the set-wins priority and the plain read/write stall control. An all-ones write against a busy FIFO shows that the read-only and reserved bits do not respond to writes.

// File: rtl/epo_csr_pkg.sv
// Package: bit positions and shared sizes for the OUT endpoint status word.
// Assumes a 32-bit CPU data path.
package epo_csr_pkg;
    localparam int CSR_W    = 32;
    localparam int B_SVC    = 0;  // one or more complete packets held
    localparam int B_DONE   = 1;  // packet complete, write 1 to clear
    localparam int B_SSENT  = 4;  // stall sent, write 1 to clear
    localparam int B_FSTALL = 5;  // force stall, read/write
    localparam int B_NEMPTY = 6;  // any byte held
    localparam int B_SHORT  = 7;  // short packet held
endpackage

// File: rtl/epo_occ_cnt.sv
// Up/down occupancy counter for FIFO bytes.
// Assumes the caller never pushes into a full FIFO or pops an empty one;
// such requests are dropped so the count stays in range.
module epo_occ_cnt #(
    parameter int MAX   = 128,
    localparam int CW   = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count
);
    logic inc_ok, dec_ok;

    // Qualify requests against the range limits.
    always_comb begin
        inc_ok = inc && (count != CW'(MAX));
        dec_ok = dec && (count != '0);
    end

    // Apply the net change once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc_ok && !dec_ok)
            count <= count + 1'b1;
        else if (dec_ok && !inc_ok)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/epo_pkt_track.sv
// Tracks the complete packets held in the receive FIFO, oldest first,
// each with a tag saying whether it was short. Drains remove the oldest.
// Assumes at most DEPTH packets are held; completions beyond that are dropped.
module epo_pkt_track #(
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          is_short,
    input  logic          drain,
    output logic [CW-1:0] count,
    output logic          any_short
);
    logic [DEPTH-1:0] tag;
    logic             drain_ok;
    logic [CW-1:0]    wr_idx;
    logic             done_ok;

    // Work out the slot the next completion lands in.
    always_comb begin
        drain_ok = drain && (count != '0);
        wr_idx   = count - CW'(drain_ok);
        done_ok  = done && (wr_idx < CW'(DEPTH));
    end

    // Shift the tags on a drain, then append the new tag on a completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag   <= '0;
            count <= '0;
        end else begin
            if (drain_ok) begin
                for (int i = 0; i < DEPTH - 1; i++)
                    tag[i] <= tag[i+1];
                tag[DEPTH-1] <= 1'b0;
            end
            if (done_ok)
                tag[wr_idx] <= is_short;
            count <= count + CW'(done_ok) - CW'(drain_ok);
        end
    end

    // Slots above the count always hold 0, so an OR covers the held packets.
    always_comb any_short = |tag;
endmodule

// File: rtl/epo_evt_bits.sv
// Sticky event bits with write-1-to-clear, plus the read/write stall control.
// Assumes the hardware set pulses are one cycle wide; a set beats a clear.
module epo_evt_bits #(
    parameter int NEVT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] set,
    input  logic            wr_en,
    input  logic [NEVT-1:0] clr_bits,
    input  logic            stall_wdata,
    output logic [NEVT-1:0] evt,
    output logic            stall
);
    // One sticky flop per event, set dominant.
    for (genvar g = 0; g < NEVT; g++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt[g] <= 1'b0;
            else if (set[g])
                evt[g] <= 1'b1;
            else if (wr_en && clr_bits[g])
                evt[g] <= 1'b0;
        end
    end

    // Stall control follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall <= 1'b0;
        else if (wr_en)
            stall <= stall_wdata;
    end
endmodule

// File: rtl/epo_csr.sv
// OUT endpoint control/status register. Combines byte occupancy, packet
// tracking and the sticky/control bits into one read word.
// Assumes single-cycle event pulses from the engine and the CPU, and
// that the engine reports drains in the order packets arrived.
module epo_csr
    import epo_csr_pkg::*;
#(
    parameter int FIFO_BYTES = 128,
    parameter int PKT_DEPTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             rx_byte_push,
    input  logic             rx_byte_pop,
    input  logic             rx_pkt_done,
    input  logic             rx_pkt_short,
    input  logic             rx_pkt_drained,
    input  logic             stall_sent,
    output logic             force_stall
);
    localparam int BCW = $clog2(FIFO_BYTES + 1);
    localparam int PCW = $clog2(PKT_DEPTH + 1);

    logic [BCW-1:0] byte_cnt;
    logic [PCW-1:0] pkt_cnt;
    logic           short_held;
    logic [1:0]     evt;      // [1] sent stall, [0] packet complete
    logic           fstall;

    epo_occ_cnt #(.MAX(FIFO_BYTES)) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rx_byte_push),
        .dec   (rx_byte_pop),
        .count (byte_cnt)
    );

    epo_pkt_track #(.DEPTH(PKT_DEPTH)) u_pkts (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (rx_pkt_done),
        .is_short  (rx_pkt_short),
        .drain     (rx_pkt_drained),
        .count     (pkt_cnt),
        .any_short (short_held)
    );

    epo_evt_bits #(.NEVT(2)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         ({stall_sent, rx_pkt_done}),
        .wr_en       (csr_wr_en),
        .clr_bits    ({csr_wdata[B_SSENT], csr_wdata[B_DONE]}),
        .stall_wdata (csr_wdata[B_FSTALL]),
        .evt         (evt),
        .stall       (fstall)
    );

    // Assemble the read word; unlisted bits stay zero.
    always_comb begin
        csr_rdata           = '0;
        csr_rdata[B_SVC]    = (pkt_cnt != '0);
        csr_rdata[B_DONE]   = evt[0];
        csr_rdata[B_SSENT]  = evt[1];
        csr_rdata[B_FSTALL] = fstall;
        csr_rdata[B_NEMPTY] = (byte_cnt != '0);
        csr_rdata[B_SHORT]  = short_held;
        force_stall         = fstall;
    end
endmodule

// File: rtl/epo_csr_chk.sv
// Checker for epo_csr: port-level properties, attached by bind.
module epo_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr_en,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        rx_byte_push,
    input logic        rx_byte_pop,
    input logic        rx_pkt_done,
    input logic        rx_pkt_short,
    input logic        rx_pkt_drained,
    input logic        stall_sent,
    input logic        force_stall
);
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[31:8] == 24'd0) && (csr_rdata[3:2] == 2'd0));

    p_stall_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en |=> (force_stall == $past(csr_wdata[5])));

    p_sent_stall_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_sent |=> csr_rdata[4]);

    p_sent_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[4] && !(csr_wr_en && csr_wdata[4])) |=> csr_rdata[4]);

    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pkt_done |=> csr_rdata[1]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_sent && csr_wr_en && csr_wdata[4]) |=> csr_rdata[4]);

    p_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pkt_done && !rx_pkt_drained) |=> csr_rdata[0]);

    p_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_push && !rx_byte_pop) |=> csr_rdata[6]);

    p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pkt_done && rx_pkt_short && !rx_pkt_drained && !csr_rdata[0])
        |=> csr_rdata[7]);
endmodule

bind epo_csr epo_csr_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_wr_en      (csr_wr_en),
    .csr_wdata      (csr_wdata),
    .csr_rdata      (csr_rdata),
    .rx_byte_push   (rx_byte_push),
    .rx_byte_pop    (rx_byte_pop),
    .rx_pkt_done    (rx_pkt_done),
    .rx_pkt_short   (rx_pkt_short),
    .rx_pkt_drained (rx_pkt_drained),
    .stall_sent     (stall_sent),
    .force_stall    (force_stall)
);

// File: tb/sim_epo_csr.sv
// Scoreboard bench for epo_csr: the driver applies one operation per cycle
// and queues the expected word from a requirement model; the monitor
// compares one cycle later, away from the active edge.
module sim_epo_csr;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        rx_byte_push = 1'b0, rx_byte_pop = 1'b0;
    logic        rx_pkt_done = 1'b0, rx_pkt_short = 1'b0, rx_pkt_drained = 1'b0;
    logic        stall_sent = 1'b0;
    logic        force_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // requirement model
    int m_bytes = 0;
    bit m_tags[$];
    bit m_fst = 0, m_sst = 0, m_rpc = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    bit          op_valid = 1'b0;
    bit          chk_valid = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    epo_csr u0 (
        .clk(clk), .rst_n(rst_n),
        .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .rx_byte_push(rx_byte_push), .rx_byte_pop(rx_byte_pop),
        .rx_pkt_done(rx_pkt_done), .rx_pkt_short(rx_pkt_short),
        .rx_pkt_drained(rx_pkt_drained), .stall_sent(stall_sent),
        .force_stall(force_stall)
    );

    function automatic logic [32:0] model_word();
        logic [31:0] w = '0;
        bit rsp = 0;
        foreach (m_tags[i]) rsp |= m_tags[i];
        w[0] = (m_tags.size() != 0);
        w[1] = m_rpc;
        w[4] = m_sst;
        w[5] = m_fst;
        w[6] = (m_bytes != 0);
        w[7] = rsp;
        return {m_fst, w};
    endfunction

    task automatic compare(input logic [32:0] act, input logic [32:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual stall=%0b word=%08h expected stall=%0b word=%08h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // driver: one operation in one clock cycle
    task automatic op(input bit push, input bit pop, input bit done, input bit shrt,
                      input bit drain, input bit sst, input bit wr,
                      input logic [31:0] wd, input string tag);
        @(negedge clk);
        rx_byte_push = push; rx_byte_pop = pop;
        rx_pkt_done = done; rx_pkt_short = shrt; rx_pkt_drained = drain;
        stall_sent = sst; csr_wr_en = wr; csr_wdata = wd;
        // model update from the requirements
        begin
            int nb = m_bytes;
            if (push && m_bytes < 128) nb++;
            if (pop && m_bytes > 0) nb--;
            m_bytes = nb;
        end
        if (drain && m_tags.size() > 0) void'(m_tags.pop_front());
        if (done && m_tags.size() < 2) m_tags.push_back(shrt);
        if (done) m_rpc = 1; else if (wr && wd[1]) m_rpc = 0;
        if (sst) m_sst = 1; else if (wr && wd[4]) m_sst = 0;
        if (wr) m_fst = wd[5];
        exp_q.push_back(model_word());
        tag_q.push_back(tag);
        op_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        rx_byte_push = 0; rx_byte_pop = 0; rx_pkt_done = 0; rx_pkt_short = 0;
        rx_pkt_drained = 0; stall_sent = 0; csr_wr_en = 0; csr_wdata = '0;
        op_valid = 1'b0;
    endtask

    always @(posedge clk) chk_valid <= op_valid;

    // monitor: compare after the edge that applied the operation
    always @(negedge clk) begin
        if (chk_valid && exp_q.size() != 0)
            compare({force_stall, csr_rdata}, exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare({force_stall, csr_rdata}, 33'd0, "R1 reset value");

        // R3: bytes without a completed packet
        op(1,0,0,0,0,0,0,0, "R3 first byte");
        op(1,0,0,0,0,0,0,0, "R3 second byte");
        op(1,1,0,0,0,0,0,0, "R3 push and pop together");
        op(0,1,0,0,0,0,0,0, "R3 pop one");
        op(0,1,0,0,0,0,0,0, "R3 drained empty");

        // R2, R7: a normal packet completes
        op(1,0,0,0,0,0,0,0, "R3 packet byte");
        op(1,0,1,0,0,0,0,0, "R2 R7 normal packet done");
        op(0,0,0,0,0,0,1,32'h0, "R7 write 0 keeps complete");
        op(0,0,0,0,0,0,1,32'h2, "R7 write 1 clears complete");

        // R4: short packet behind the normal one
        op(1,0,1,1,0,0,0,0, "R4 short packet done");
        op(0,1,0,0,0,0,0,0, "R2 pop byte of first packet");
        op(0,1,0,0,1,0,0,0, "R4 first drain keeps short, R2 count one");
        op(0,1,0,0,0,0,0,0, "R3 pop last byte");
        op(0,0,0,0,1,0,0,0, "R4 short drained, R2 empty");

        // R2: third completion beyond depth is dropped
        op(1,0,1,0,0,0,0,0, "R2 pkt A");
        op(0,0,1,1,0,0,0,0, "R2 pkt B");
        op(0,0,1,1,0,0,0,0, "R2 pkt C over depth");
        op(0,0,0,0,1,0,0,0, "R2 drain A");
        op(0,0,1,0,1,0,0,0, "R2 R4 drain B with new completion");
        op(0,0,0,0,1,0,0,0, "R2 drain");
        op(0,1,0,0,0,0,1,32'h2, "R7 clear complete");

        // R5: force stall
        op(0,0,0,0,0,0,1,32'h20, "R5 set force stall");
        op(0,0,0,0,0,0,1,32'h10, "R5 write without bit 5 clears stall");
        op(0,0,0,0,0,0,1,32'h20, "R5 set again");

        // R6: sent stall
        op(0,0,0,0,0,1,0,0, "R6 stall sent sets");
        op(0,0,0,0,0,0,1,32'h20, "R6 write 0 keeps sent stall");
        op(0,0,0,0,0,0,1,32'h30, "R6 write 1 clears sent stall");

        // R8: set and clear in one cycle
        op(0,0,0,0,0,1,1,32'h10, "R8 sent stall set wins");
        op(0,0,1,0,0,0,1,32'h02, "R8 complete set wins");

        // R9: all-ones write against a busy FIFO
        op(1,0,1,1,0,0,0,0, "R4 short packet for R9");
        op(0,0,0,0,0,0,1,32'hFFFF_FFFF, "R9 all ones write");
        op(0,0,0,0,0,0,1,32'h0000_0000, "R9 zero write");
        op(0,1,0,0,1,0,0,0, "R9 drain to empty");

        idle();
        idle();
        idle();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule